// File: doc/BRIEF.md
# General-Purpose Pin Bank Controller

A register-mapped controller for a bank of general-purpose pins. Each pin is driven either by the controller or by a peripheral function, chosen pin by pin. When the controller drives a pin, two registers give the output level and the output enable. On the input side, each pin's level can go through an optional glitch filter, and any change of that level is latched into a status bit. The status bits, masked by per-pin enables, raise one interrupt line.

Every register that software changes often has three word addresses. A write to the first sets the bits written as 1. A write to the second clears the bits written as 1. The third reads the value. Zero bits in a set or clear write change nothing, so firmware can change single pins without a read-modify-write. Access is through a simple APB-style port: a setup cycle, then an access cycle with `penable` high.

Top module: `pio_bank`

## Requirements
- R1: After reset, every pin is owned by the controller (ownership register reads all ones). The output-enable, output-level, filter-enable and interrupt-enable registers read zero, the change status reads zero, `pad_oe` is zero and `irq` is low.
- R2: Register block k (own=0, oe=1, out=2, filter=3, irq-enable=4) sits at byte address 16*k. Offset +0 sets bits, +4 clears bits and +8 reads the register. A write at +0 sets every bit that is 1 in the write data.
- R3: Bits written as 0 through a set or a clear address keep their value.
- R4: A write at +4 clears every bit that is 1 in the write data.
- R5: A pin whose ownership bit is 1 drives `pad_out`/`pad_oe` from the output-level and output-enable registers. A pin whose ownership bit is 0 passes `periph_out`/`periph_oe` through.
- R6: With its filter bit set, a pin's level takes a new input value only after two consecutive equal samples, so a one-cycle pulse is suppressed. Without the filter, the same pulse is seen.
- R7: Any change of a pin's (filtered or raw) level, rising or falling, sets that pin's bit in the change status register.
- R8: The change status register reads at byte address 0x60 and is cleared by the read. A change that occurs in the read's access cycle is kept for the next read.
- R9: `irq` is high exactly when some status bit is 1 and its interrupt-enable bit is also 1.
- R10: The level register at byte address 0x50 returns the current per-pin level (filtered where enabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | NPINS | Write data, one bit per pin |
| prdata | output | NPINS | Read data |
| pin_in | input | NPINS | Pad input levels |
| periph_out | input | NPINS | Peripheral output levels |
| periph_oe | input | NPINS | Peripheral output enables |
| pad_out | output | NPINS | Level driven to pads |
| pad_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Change interrupt |

## Verification
Two events can meet in one cycle: the clear caused by reading the status register, and a fresh input change latched into it. The bench toggles a pin during the setup cycle of a status read, so the detected change lands exactly in the access cycle. It then expects that read to return zero for that pin and the next read to return the bit set. A one-cycle pulse driven on a filtered pin and an unfiltered pin at the same time checks that only the unfiltered pin reports the change.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // register block indices (byte address = 16 * index)
  localparam int REG_OWN  = 0;
  localparam int REG_OE   = 1;
  localparam int REG_OUT  = 2;
  localparam int REG_FILT = 3;
  localparam int REG_IEN  = 4;
  localparam int NREG     = 5;
  localparam logic [2:0] BLK_LEVEL  = 3'd5;
  localparam logic [2:0] BLK_STATUS = 3'd6;
  // word offsets inside a block
  localparam logic [1:0] OP_SET  = 2'd0;
  localparam logic [1:0] OP_CLR  = 2'd1;
  localparam logic [1:0] OP_READ = 2'd2;

  // next register value after an optional set and/or clear write
  function automatic logic [31:0] setclr_next(input logic [31:0] q, input logic set_we,
                                              input logic clr_we, input logic [31:0] wd);
    logic [31:0] s, c;
    s = set_we ? wd : 32'd0;
    c = clr_we ? wd : 32'd0;
    return (q | s) & ~c;
  endfunction

  // two-sample glitch filter: accept only when both samples agree
  function automatic logic filt_next(input logic s0, input logic s1, input logic q);
    return (s0 == s1) ? s0 : q;
  endfunction
endpackage

// File: rtl/pio_setclr_reg.sv
module pio_setclr_reg import pio_pkg::*; #(
  parameter int W = 24,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [31:0] nxt;
  assign nxt = setclr_next(32'(q), set_we, clr_we, 32'(wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RSTV;
    else        q <= nxt[W-1:0];
  end

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(wdata)) == $past(wdata)));
  p_zero_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we || clr_we) |=> (((q ^ $past(q)) & ~$past(wdata)) == '0));
  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/pio_in_stage.sv
module pio_in_stage import pio_pkg::*; #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] flt_en,
  output logic [W-1:0] level,
  output logic [W-1:0] change
);
  logic [W-1:0] samp0, samp1, flt_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp0  <= '0;
      samp1  <= '0;
      prev_q <= '0;
    end else begin
      samp0  <= pin_in;
      samp1  <= samp0;
      prev_q <= level;
    end
  end

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q[b] <= 1'b0;
        else        flt_q[b] <= filt_next(samp0[b], samp1[b], flt_q[b]);
      end

      p_filter_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q[b] != $past(flt_q[b])) |-> (($past(samp0[b]) == $past(samp1[b])) && (flt_q[b] == $past(samp0[b]))));
    end
  endgenerate

  assign level  = (flt_en & flt_q) | (~flt_en & samp0);
  assign change = level ^ prev_q;
endmodule

// File: rtl/pio_chg_status.sv
module pio_chg_status #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] change,
  input  logic         rd_clr,
  input  logic [W-1:0] ien,
  output logic [W-1:0] status,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (rd_clr ? '0 : status) | change;
  end

  assign irq = |(status & ien);

  p_change_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (change != '0) |=> ((status & $past(change)) == $past(change)));
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && change == '0) |=> (status == '0));
  p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & ien) != '0));
endmodule

// File: rtl/pio_bank.sv
module pio_bank import pio_pkg::*; #(
  parameter int NPINS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [7:0]       paddr,
  input  logic [NPINS-1:0] pwdata,
  output logic [NPINS-1:0] prdata,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] periph_out,
  input  logic [NPINS-1:0] periph_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  logic             access, addr_ok, rd_clr;
  logic [2:0]       blk;
  logic [1:0]       op;
  logic [NPINS-1:0] regq [NREG];
  logic [NPINS-1:0] level, change, status;

  assign access  = psel & penable;
  assign addr_ok = (paddr[1:0] == 2'b00) && !paddr[7];
  assign blk     = paddr[6:4];
  assign op      = paddr[3:2];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic set_we, clr_we;
      assign set_we = access & pwrite & addr_ok & (blk == 3'(g)) & (op == OP_SET);
      assign clr_we = access & pwrite & addr_ok & (blk == 3'(g)) & (op == OP_CLR);
      pio_setclr_reg #(
        .W(NPINS),
        .RSTV((g == REG_OWN) ? {NPINS{1'b1}} : {NPINS{1'b0}})
      ) u_reg (
        .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
        .wdata(pwdata), .q(regq[g])
      );
    end
  endgenerate

  pio_in_stage #(.W(NPINS)) u_in (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .flt_en(regq[REG_FILT]),
    .level(level), .change(change)
  );

  assign rd_clr = access & !pwrite & addr_ok & (blk == BLK_STATUS) & (op == OP_READ - 2'd2);

  pio_chg_status #(.W(NPINS)) u_chg (
    .clk(clk), .rst_n(rst_n), .change(change), .rd_clr(rd_clr),
    .ien(regq[REG_IEN]), .status(status), .irq(irq)
  );

  // pad multiplexer: controller-owned pins use own registers
  assign pad_out = (regq[REG_OWN] & regq[REG_OUT]) | (~regq[REG_OWN] & periph_out);
  assign pad_oe  = (regq[REG_OWN] & regq[REG_OE])  | (~regq[REG_OWN] & periph_oe);

  always_comb begin
    prdata = '0;
    if (addr_ok) begin
      unique case (blk)
        3'd0: if (op == OP_READ) prdata = regq[REG_OWN];
        3'd1: if (op == OP_READ) prdata = regq[REG_OE];
        3'd2: if (op == OP_READ) prdata = regq[REG_OUT];
        3'd3: if (op == OP_READ) prdata = regq[REG_FILT];
        3'd4: if (op == OP_READ) prdata = regq[REG_IEN];
        BLK_LEVEL:  if (op == 2'd0) prdata = level;
        BLK_STATUS: if (op == 2'd0) prdata = status;
        default: prdata = '0;
      endcase
    end
  end

  p_owned_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (regq[REG_OWN] == '0) |-> (pad_oe == periph_oe));
endmodule

// File: tb/test_pio_bank.sv
module test_pio_bank;
  localparam int N = 24;
  localparam logic [7:0] A_LEVEL  = 8'h50;
  localparam logic [7:0] A_STATUS = 8'h60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [N-1:0] pwdata = '0, pin_in = '0, periph_out = '0, periph_oe = '0;
  logic [N-1:0] prdata, pad_out, pad_oe;
  logic irq;

  always #2 clk = ~clk;

  pio_bank #(.NPINS(N)) i_pio_bank (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .periph_out(periph_out), .periph_oe(periph_oe), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  typedef struct {
    logic [N-1:0] val;
    logic [N-1:0] mask;
    string        tag;
  } exp_t;
  exp_t expq[$];
  event mon_ev;
  int n_chk = 0, n_fail = 0;

  function automatic logic [7:0] adr(input int blk, input int op);
    return 8'(blk * 16 + op * 4);
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares with the bus
  always begin
    @(mon_ev);
    if (expq.size() != 0) begin
      exp_t e;
      e = expq.pop_front();
      if (e.mask != '0) check(e.tag, prdata & e.mask, e.val & e.mask);
    end
  end

  task automatic apb_write(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [7:0] a, input logic [N-1:0] exp,
                          input logic [N-1:0] mask, input string tag,
                          input logic [N-1:0] tgl = '0);
    exp_t e;
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    pin_in = pin_in ^ tgl;
    @(negedge clk);
    penable = 1'b1;
    e.val = exp; e.mask = mask; e.tag = tag;
    expq.push_back(e);
    #1 -> mon_ev;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 irq", N'(irq), '0);
    apb_read(adr(0, 2), '1, '1, "R1 own");
    apb_read(adr(1, 2), '0, '1, "R1 oe");
    apb_read(adr(3, 2), '0, '1, "R1 filter");
    apb_read(adr(4, 2), '0, '1, "R1 ien");
    apb_read(A_STATUS, '0, '1, "R1 status");

    // R2 set, R3 zero bits, R4 clear
    apb_write(adr(1, 0), 24'h0000F0);
    apb_read(adr(1, 2), 24'h0000F0, '1, "R2 oe set");
    apb_write(adr(2, 0), 24'h0000A0);
    idle(1);
    check("R5 pad_out owned", pad_out, 24'h0000A0);
    check("R5 pad_oe owned", pad_oe, 24'h0000F0);
    apb_write(adr(1, 0), 24'h000003);
    apb_read(adr(1, 2), 24'h0000F3, '1, "R3 set keeps zeros");
    apb_write(adr(1, 1), 24'h000030);
    apb_read(adr(1, 2), 24'h0000C3, '1, "R4 oe clear");
    apb_write(adr(1, 1), 24'h000000);
    apb_read(adr(1, 2), 24'h0000C3, '1, "R3 clear of zeros");

    // R5 peripheral ownership
    periph_oe = '1; periph_out = 24'h555555;
    apb_write(adr(0, 1), 24'h0000FF);
    apb_read(adr(0, 2), 24'hFFFF00, '1, "R4 own clear");
    idle(1);
    check("R5 pad_oe mixed", pad_oe, 24'h0000FF);
    check("R5 pad_out mixed", pad_out, 24'h000055);
    apb_write(adr(0, 0), 24'h0000FF);
    idle(1);
    check("R5 pad_oe back", pad_oe, 24'h0000C3);

    // R7 change detection on raw input, both edges; R8 clear on read; R10 level
    apb_read(A_STATUS, '0, '0, "clear");
    pin_in[0] = 1'b1;
    idle(4);
    apb_read(A_LEVEL, 24'h000001, '1, "R10 level");
    apb_read(A_STATUS, 24'h000001, '1, "R7 rise");
    apb_read(A_STATUS, '0, '1, "R8 cleared");
    check("R9 irq masked", N'(irq), '0);
    pin_in[0] = 1'b0;
    idle(4);
    apb_read(A_STATUS, 24'h000001, '1, "R7 fall");

    // R9 interrupt
    apb_write(adr(4, 0), 24'h000004);
    pin_in[2] = 1'b1;
    idle(4);
    check("R9 irq high", N'(irq), 24'h1);
    apb_read(A_STATUS, 24'h000004, '1, "R9 status");
    idle(1);
    check("R9 irq low after read", N'(irq), '0);

    // R6 filter: one-cycle pulse on filtered pin1 and raw pin3
    apb_write(adr(3, 0), 24'h000002);
    idle(3);
    apb_read(A_STATUS, '0, '0, "clear");
    @(negedge clk); pin_in[1] = 1'b1; pin_in[3] = 1'b1;
    @(negedge clk); pin_in[1] = 1'b0; pin_in[3] = 1'b0;
    idle(6);
    apb_read(A_STATUS, 24'h000008, '1, "R6 pulse filtered vs raw");
    pin_in[1] = 1'b1;
    idle(6);
    apb_read(A_STATUS, 24'h000002, '1, "R6 stable passes");
    apb_read(A_LEVEL, 24'h000006, '1, "R10 filtered level");

    // R8 change in the same cycle as the clearing read
    apb_read(A_STATUS, '0, '1, "R8 pre");
    apb_read(A_STATUS, '0, '1, "R8 read during change", 24'h000010);
    idle(2);
    apb_read(A_STATUS, 24'h000010, '1, "R8 change kept");

    idle(4);
    finish_run();
  end
endmodule